// File: doc/BRIEF.md
# Programmable Input Qualification Filter

This block cleans up slow asynchronous digital inputs, such as capture or count-direction pins, before timer and capture logic sees them. Each raw pin is brought into the clock domain by a two-stage synchronizer. A single prescaler shared by all channels produces a sample strobe once every 2×n clock cycles, where n is the 8-bit period input. Each channel accepts a new level only after six consecutive strobed samples agree, which spans five sample windows. Until then the qualified output keeps its old level.

A period of zero selects bypass: the synchronized pin drives the registered output directly. Changing the period value restarts the prescaler count. Each channel runs a two-state machine. `ST_STEADY` means no disagreeing sample is pending. `ST_TRACK` means a candidate level differs from the output and is being counted. The transitions are:
- steady→track when a strobed sample differs from the output.
- track→steady (restart) when a sample matches the output again.
- track→steady (accept) on the sixth agreeing sample, which also updates the output.
- any state→steady when bypass is active.

Top module: `pin_qualifier`

## Requirements
- R1: While `rst_n` is low and directly after it is released, every bit of `qual_o` is 0.
- R2: With `period_i` = 0, `qual_o` equals `pin_i` with a latency of exactly three clock edges (two synchronizer stages plus the output register).
- R3: With a constant nonzero `period_i` = n, sample strobes occur exactly 2×n clock cycles apart; 255 therefore gives a 510-cycle window.
- R4: With nonzero n, a pulse of 10×n clock cycles or less on a pin never changes that channel's output.
- R5: With nonzero n, a pulse of at least 12×n cycles always sets the output to the new level no later than 4 cycles after the pulse ends, whatever its phase to the prescaler.
- R6: The filter is symmetric: a low run of at least 12×n cycles returns a qualified high output to 0.
- R7: A sample that disagrees with the candidate restarts the count, so high runs of 6×n cycles separated by 2×n-cycle low gaps never qualify.
- R8: Any change of `period_i` restarts the prescaler; a period that keeps changing faster than one window produces no strobe, so no output changes.
- R9: At period 255 a constant new level is still rejected after 2550 cycles and accepted within 3064 cycles.
- R10: Channels are independent: activity on one pin never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | 8 | Qualification period n; 0 selects bypass |
| pin_i | input | CH | Raw asynchronous pins |
| qual_o | output | CH | Qualified levels |

## Verification
Bypass is swept over all 16 input patterns, which shows both the exact three-edge latency and the bit-to-bit mapping. For periods 1 to 3, pulses of 10×n and 12×n cycles are launched at every prescaler phase. This separates the never-accepted width from the always-accepted one and checks that the return to zero is symmetric. A broken high run shows that a disagreeing sample restarts the count. A rapidly rewritten period shows that the prescaler restarts. A run at period 255 checks the largest window from both sides of its threshold.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int AGREE_N = 6;
    localparam int CNT_W   = $clog2(AGREE_N);
    typedef enum logic {ST_STEADY, ST_TRACK} qual_st_e;
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
    parameter int CH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] raw_i,
    output logic [CH-1:0] sync_o
);
    logic [CH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= raw_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/pq_prescaler.sv
module pq_prescaler #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    output logic [PER_W-1:0] period_q,
    output logic             strobe_o,
    output logic             bypass_o
);
    localparam int PRE_W = PER_W + 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;
    logic             changed;

    assign limit    = {period_q, 1'b0} - PRE_W'(1);
    assign changed  = (period_i != period_q);
    assign bypass_o = (period_q == '0);
    assign strobe_o = !bypass_o && !changed && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt      <= '0;
        end else if (changed) begin
            period_q <= period_i;
            cnt      <= '0;
        end else if (bypass_o || cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pq_channel.sv
module pq_channel
    import pq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,
    input  logic             strobe_i,
    input  logic             sample_i,
    output logic             qual_o,
    output logic [CNT_W-1:0] agree_o
);
    qual_st_e         st, st_n;
    logic             cand, cand_n;
    logic             q_n;
    logic [CNT_W-1:0] cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_STEADY;
            cand    <= 1'b0;
            qual_o  <= 1'b0;
            agree_o <= '0;
        end else begin
            st      <= st_n;
            cand    <= cand_n;
            qual_o  <= q_n;
            agree_o <= cnt_n;
        end
    end

    always_comb begin
        st_n   = st;
        cand_n = cand;
        q_n    = qual_o;
        cnt_n  = agree_o;
        if (bypass_i) begin
            st_n   = ST_STEADY;
            cand_n = sample_i;
            q_n    = sample_i;
            cnt_n  = '0;
        end else if (strobe_i) begin
            unique case (st)
                ST_STEADY: begin
                    if (sample_i != qual_o) begin
                        st_n   = ST_TRACK;
                        cand_n = sample_i;
                        cnt_n  = CNT_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (sample_i != cand) begin
                        st_n  = ST_STEADY;
                        cnt_n = '0;
                    end else if (agree_o == CNT_W'(AGREE_N - 1)) begin
                        st_n  = ST_STEADY;
                        q_n   = cand;
                        cnt_n = '0;
                    end else begin
                        cnt_n = agree_o + CNT_W'(1);
                    end
                end
                default: st_n = ST_STEADY;
            endcase
        end
    end
endmodule

// File: rtl/pin_qualifier.sv
module pin_qualifier
    import pq_pkg::*;
#(
    parameter int CH    = 4,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    input  logic [CH-1:0]    pin_i,
    output logic [CH-1:0]    qual_o
);
    logic [CH-1:0]             sync_w;
    logic [PER_W-1:0]          per_q;
    logic                      strobe;
    logic                      bypass;
    logic [CH-1:0][CNT_W-1:0]  cnt_w;

    pq_sync #(.CH(CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(sync_w)
    );

    pq_prescaler #(.PER_W(PER_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .period_i(period_i),
        .period_q(per_q), .strobe_o(strobe), .bypass_o(bypass)
    );

    for (genvar g = 0; g < CH; g++) begin : g_ch
        pq_channel u_ch (
            .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .strobe_i(strobe),
            .sample_i(sync_w[g]), .qual_o(qual_o[g]), .agree_o(cnt_w[g])
        );
    end
endmodule

// File: rtl/pq_checker.sv
module pq_checker
    import pq_pkg::*;
#(
    parameter int CH    = 4,
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PER_W-1:0] per_i,
    input logic [PER_W-1:0] per_q,
    input logic             strobe,
    input logic [CH-1:0]    sync,
    input logic [CH-1:0]    q,
    input logic [CNT_W-1:0] cnt0
);
    logic [PER_W+1:0] gap;
    logic             seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else begin
            if (strobe) begin
                gap  <= (PER_W+2)'(1);
                seen <= 1'b1;
            end else begin
                if (gap != '1) gap <= gap + (PER_W+2)'(1);
                if (per_i != per_q) seen <= 1'b0;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> q == '0);

    a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0 && $past(per_q) == '0) |-> q == $past(sync));

    a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && seen) |-> gap == {1'b0, per_q, 1'b0});

    a_r5_change_on_sixth: assert property (@(posedge clk) disable iff (!rst_n)
        (q[0] != $past(q[0]) && $past(per_q) != '0)
        |-> ($past(strobe) && $past(cnt0) == CNT_W'(AGREE_N - 1)));

    a_r8_no_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (per_i != per_q) |-> !strobe);
endmodule

bind pin_qualifier pq_checker #(.CH(CH), .PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .per_i(period_i), .per_q(per_q),
    .strobe(strobe), .sync(sync_w), .q(qual_o), .cnt0(cnt_w[0])
);

// File: tb/test_pin_qualifier.sv
`timescale 1ns/1ps
module test_pin_qualifier;
    localparam int CH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    period = '0;
    logic [CH-1:0] pin = '0;
    logic [CH-1:0] qual;
    int            n_run = 0;
    int            n_fail = 0;
    bit            seen1;
    bit            others_hit;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    pin_qualifier #(.CH(CH), .PER_W(8)) i_pin_qualifier (
        .clk(clk), .rst_n(rst_n), .period_i(period), .pin_i(pin), .qual_o(qual)
    );

    always @(negedge clk) begin
        if (qual[0]) seen1 = 1'b1;
        if (qual[CH-1:1] != '0) others_hit = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int w);
        pin[0] = 1'b1;
        cycles(w);
        pin[0] = 1'b0;
    endtask

    initial begin
        #1;
        @(negedge clk);
        check(qual == '0, "R1 in reset", qual, 0);
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(qual == '0, "R1 after release", qual, 0);

        // R2: bypass, all 16 patterns
        for (int p = 0; p < 16; p++) begin
            @(posedge clk); #1;
            pin = CH'(p);
            @(posedge clk); @(posedge clk); @(negedge clk);
            if (p > 0) check(qual == CH'(p - 1), "R2 latency not early", qual, p - 1);
            @(posedge clk); @(negedge clk);
            check(qual == CH'(p), "R2 bypass value", qual, p);
        end
        @(posedge clk); #1;
        pin = '0;
        cycles(4);

        // R4/R5/R6/R10 sweep over periods and phases
        for (int n = 1; n <= 3; n++) begin
            period = 8'(n);
            cycles(20 * n);
            for (int off = 0; off < 2 * n; off++) begin
                cycles(off + 1);
                seen1 = 1'b0; others_hit = 1'b0;
                pulse(10 * n);
                cycles(14 * n + 4);
                check(!seen1, "R4 short pulse rejected", seen1, 0);
                check(!others_hit, "R10 other channels quiet", others_hit, 0);
                cycles(off + 1);
                seen1 = 1'b0;
                pulse(12 * n);
                cycles(4);
                check(seen1, "R5 long pulse accepted", seen1, 1);
                cycles(12 * n + 4);
                @(negedge clk);
                check(qual[0] == 1'b0, "R6 long low returns to 0", qual[0], 0);
                #1;
            end
        end

        // R7: broken high runs
        period = 8'd2;
        cycles(40);
        seen1 = 1'b0;
        pulse(12);
        cycles(4);
        pulse(12);
        cycles(4);
        pulse(12);
        cycles(40);
        check(!seen1, "R7 disagreeing sample restarts", seen1, 0);

        // R8: period rewritten faster than a window
        seen1 = 1'b0;
        pin[0] = 1'b1;
        for (int k = 0; k < 40; k++) begin
            period = (k % 2 == 0) ? 8'd3 : 8'd4;
            cycles(5);
        end
        check(!seen1, "R8 restarts starve strobes", seen1, 0);
        period = 8'd3;
        cycles(12 * 3 + 4);
        check(seen1, "R8 stable period then accepts", seen1, 1);
        pin[0] = 1'b0;
        cycles(12 * 3 + 8);
        @(negedge clk);
        check(qual == '0, "R6 cleared before R9", qual, 0);
        #1;

        // R9: largest window
        period = 8'd255;
        cycles(3);
        pin = '1;
        cycles(2550);
        @(negedge clk);
        check(qual == '0, "R9 rejected at 2550", qual, 0);
        #1;
        cycles(3064 - 2550);
        @(negedge clk);
        check(qual == '1, "R9/R10 accepted within 3064", qual, 15);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule